// File: doc/BRIEF.md
# Cyclic M-Fold Strip Coincidence Trigger

This block produces the first-level trigger for one detector plane. It takes 32 discriminated strip hits and folds them into 8 interleaved group lines. Group line n collects strips n, n+8, n+16 and n+24. The block then looks for runs of adjacent active groups on a ring, so that the last group counts as the neighbour of the first. The result is one flag for each run length from 1 to 4.

Each strip first passes through a two-flop synchronizer, because the hits arrive asynchronously from the discriminators. A per-strip mask can then silence the strip. The group lines and fold flags leave the block through one output register. The 1-fold flag, which is the OR of all groups, is also the stop signal for the plane's time-to-digital converter, so its timing matters as much as its value.

Top module: `sfc_coinc_top`

## Requirements
- R1: While rst_n is low, group_o and fold_o are all zero.
- R2: A change on strip_i is seen on the outputs after the third rising clock edge following it: two edges in the synchronizer and one in the output register. A change on mask_i is seen after the first edge.
- R3: group_o[n] (0-based) is the OR of the unmasked synchronized strips n, n+8, n+16 and n+24.
- R4: fold_o[0] is the OR of all eight group values.
- R5: fold_o[1] is set when any two cyclically adjacent groups are both active, and the pair (7, 0) counts as adjacent.
- R6: fold_o[2] and fold_o[3] are set when 3, or 4, cyclically consecutive groups are all active, with group indices taken modulo 8.
- R7: When mask_i[i] is set, strip i has no effect on any output.
- R8: A strip hit held for one clock cycle gives group and fold outputs that are set for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strip_i | input | 32 | Discriminated strip hits, asynchronous |
| mask_i | input | 32 | Per-strip suppression, 1 = suppressed |
| group_o | output | 8 | Registered interleaved group lines |
| fold_o | output | 4 | Registered fold flags; bit m-1 is the m-fold flag |

## Verification
The wrap-around windows are the hardest case to reach. They need hits on groups 7 and 0, or runs such as 6-7-0-1, and they only show up if each group is driven through a strip other than the obvious one. The stimulus therefore builds ring windows from strips in different quarters of the strip range, at every start position. The mask has to be checked together with the three-edge pipeline, because the mask acts one cycle after the sync stage. For that reason the reference model keeps a queue of the applied strip words and pairs the strip word from two edges back with the current mask.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int SFC_STRIPS = 32;
  localparam int SFC_GROUPS = 8;
  localparam int SFC_FOLDS  = 4;
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d;
  logic [W-1:0] stab_q;
  logic [W-1:0] stab_d;
  logic         samp_en;

  assign samp_en = 1'b1;

  always_comb begin
    meta_d = meta_q;
    stab_d = stab_q;
    if (samp_en) begin
      meta_d = d_i;
      stab_d = meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/sfc_group_or.sv
module sfc_group_or #(
  parameter int STRIPS = 32,
  parameter int GROUPS = 8
) (
  input  logic [STRIPS-1:0] strip_i,
  input  logic [STRIPS-1:0] mask_i,
  output logic [GROUPS-1:0] group_o
);
  localparam int MEMBERS = STRIPS / GROUPS;

  logic [STRIPS-1:0] live;
  assign live = strip_i & ~mask_i;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int j = 0; j < MEMBERS; j++) begin
        acc = acc | live[g + j*GROUPS];
      end
    end
    assign group_o[g] = acc;
  end
endmodule

// File: rtl/sfc_fold_ring.sv
module sfc_fold_ring #(
  parameter int GROUPS = 8,
  parameter int FOLDS  = 4
) (
  input  logic [GROUPS-1:0] group_i,
  output logic [FOLDS-1:0]  fold_o
);
  for (genvar m = 1; m <= FOLDS; m++) begin : g_fold
    logic [GROUPS-1:0] win;
    for (genvar k = 0; k < GROUPS; k++) begin : g_start
      logic all_on;
      always_comb begin
        all_on = 1'b1;
        for (int j = 0; j < m; j++) begin
          all_on = all_on & group_i[(k + j) % GROUPS];
        end
      end
      assign win[k] = all_on;
    end
    assign fold_o[m-1] = |win;
  end
endmodule

// File: rtl/sfc_coinc_top.sv
module sfc_coinc_top #(
  parameter int STRIPS = sfc_pkg::SFC_STRIPS,
  parameter int GROUPS = sfc_pkg::SFC_GROUPS,
  parameter int FOLDS  = sfc_pkg::SFC_FOLDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STRIPS-1:0] strip_i,
  input  logic [STRIPS-1:0] mask_i,
  output logic [GROUPS-1:0] group_o,
  output logic [FOLDS-1:0]  fold_o
);
  logic [STRIPS-1:0] strip_sync;
  logic [GROUPS-1:0] grp_comb;
  logic [FOLDS-1:0]  fold_comb;
  logic [GROUPS-1:0] grp_q, grp_d;
  logic [FOLDS-1:0]  fold_q, fold_d;
  logic              out_en;

  sfc_sync #(.W(STRIPS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (strip_i),
    .q_o   (strip_sync)
  );

  sfc_group_or #(.STRIPS(STRIPS), .GROUPS(GROUPS)) u_grp (
    .strip_i (strip_sync),
    .mask_i  (mask_i),
    .group_o (grp_comb)
  );

  sfc_fold_ring #(.GROUPS(GROUPS), .FOLDS(FOLDS)) u_ring (
    .group_i (grp_comb),
    .fold_o  (fold_comb)
  );

  assign out_en = 1'b1;

  always_comb begin
    grp_d  = grp_q;
    fold_d = fold_q;
    if (out_en) begin
      grp_d  = grp_comb;
      fold_d = fold_comb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      fold_q <= '0;
    end else begin
      grp_q  <= grp_d;
      fold_q <= fold_d;
    end
  end

  assign group_o = grp_q;
  assign fold_o  = fold_q;
endmodule

// File: rtl/sfc_coinc_chk.sv
module sfc_coinc_chk #(
  parameter int STRIPS = 32,
  parameter int GROUPS = 8,
  parameter int FOLDS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STRIPS-1:0] mask_i,
  input logic [GROUPS-1:0] group_o,
  input logic [FOLDS-1:0]  fold_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (group_o == '0 && fold_o == '0));

  p_any_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fold_o[0] == (|group_o));

  if (FOLDS >= 2) begin : g_pair
    p_ring_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fold_o[1] == (|(group_o & {group_o[0], group_o[GROUPS-1:1]})));
  end

  for (genvar m = 1; m < FOLDS; m++) begin : g_nest
    p_fold_nested_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fold_o[m] |-> fold_o[m-1]);
  end

  p_full_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&mask_i) |-> (group_o == '0 && fold_o == '0));
endmodule

bind sfc_coinc_top sfc_coinc_chk #(
  .STRIPS(STRIPS), .GROUPS(GROUPS), .FOLDS(FOLDS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mask_i  (mask_i),
  .group_o (group_o),
  .fold_o  (fold_o)
);

// File: tb/tb_sfc_coinc_top.sv
module tb_sfc_coinc_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] strip_i;
  logic [31:0] mask_i;
  logic [7:0]  group_o;
  logic [3:0]  fold_o;

  int tests_run;
  int tests_failed;
  bit finished;
  logic [31:0] sq[$];
  logic [31:0] mq[$];

  sfc_coinc_top dut (
    .clk(clk), .rst_n(rst_n), .strip_i(strip_i), .mask_i(mask_i),
    .group_o(group_o), .fold_o(fold_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] ref_groups(input logic [31:0] v);
    logic [7:0] g;
    g = '0;
    for (int i = 0; i < 32; i++) if (v[i]) g[i % 8] = 1'b1;
    return g;
  endfunction

  function automatic logic [3:0] ref_folds(input logic [7:0] g);
    logic [3:0] f;
    f = '0;
    for (int m = 1; m <= 4; m++) begin
      for (int k = 0; k < 8; k++) begin
        int run;
        run = 0;
        for (int j = 0; j < m; j++) if (g[(k + j) % 8]) run++;
        if (run == m) f[m-1] = 1'b1;
      end
    end
    return f;
  endfunction

  task automatic check_outputs(input string tag);
    logic [7:0] eg;
    logic [3:0] ef;
    int n;
    n = sq.size();
    eg = ref_groups(sq[n-3] & ~mq[mq.size()-1]);
    ef = ref_folds(eg);
    tests_run++;
    if (group_o !== eg) begin
      tests_failed++;
      $display("FAIL %s group_o actual=%b expected=%b", tag, group_o, eg);
    end
    tests_run++;
    if (fold_o !== ef) begin
      tests_failed++;
      $display("FAIL %s fold_o actual=%b expected=%b", tag, fold_o, ef);
    end
  endtask

  // called at a negedge: drive, let one edge consume, check at next negedge
  task automatic cycle(input logic [31:0] s, input logic [31:0] m, input string tag);
    strip_i = s;
    mask_i  = m;
    @(posedge clk);
    sq.push_back(s);
    mq.push_back(m);
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic strip_of_group(input int g, input int quarter, inout logic [31:0] v);
    v[(g % 8) + 8*(quarter % 4)] = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    tests_run = 0;
    tests_failed = 0;
    finished = 0;
    rst_n = 1'b0;
    strip_i = '1;
    mask_i = '0;
    repeat (3) begin
      @(negedge clk);
      tests_run++;
      if (group_o !== '0 || fold_o !== '0) begin
        tests_failed++;
        $display("FAIL R1 reset outputs actual=%b/%b expected=0/0", group_o, fold_o);
      end
    end
    strip_i = '0;
    @(negedge clk);
    rst_n = 1'b1;
    sq.push_back('0);
    sq.push_back('0);

    // R2: latency of strip path and of mask path
    repeat (3) cycle('0, '0, "R2");
    repeat (4) cycle(32'h0000_0020, '0, "R2");
    cycle(32'h0000_0020, 32'h0000_0020, "R2");
    cycle(32'h0000_0020, '0, "R2");
    repeat (3) cycle('0, '0, "R2");

    // R3: each strip alone
    for (int i = 0; i < 32; i++) cycle(32'h1 << i, '0, "R3");
    repeat (3) cycle('0, '0, "R3");

    // R4: non-adjacent groups only
    cycle(32'h0055_0000, '0, "R4");
    cycle(32'h5500_0000, '0, "R4");
    cycle(32'h0000_00AA, '0, "R4");
    repeat (3) cycle('0, '0, "R4");

    // R5/R6: ring windows at every start, built from mixed quarters
    for (int len = 2; len <= 4; len++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] v;
        v = '0;
        for (int j = 0; j < len; j++) strip_of_group(k + j, k + j, v);
        cycle(v, '0, len == 2 ? "R5" : "R6");
      end
    end
    repeat (3) cycle('0, '0, "R6");

    // R7: masking
    cycle('1, '0, "R7");
    repeat (3) cycle('1, 32'h0808_0808, "R7");
    repeat (3) cycle('1, 32'hFFFF_FFFF, "R7");
    repeat (3) cycle(32'h0000_0081, 32'h0000_0001, "R7");
    repeat (3) cycle(32'h0100_8000, 32'h0000_8000, "R7");
    repeat (3) cycle('0, '0, "R7");

    // R8: single-cycle pulses
    cycle(32'h0000_0300, '0, "R8");
    repeat (4) cycle('0, '0, "R8");
    cycle(32'h8000_0001, '0, "R8");
    repeat (4) cycle('0, '0, "R8");

    // R4: random sparse traffic with random masks
    for (int t = 0; t < 400; t++) begin
      logic [31:0] s, m;
      s = $urandom() & $urandom() & $urandom();
      m = $urandom() & $urandom() & $urandom() & $urandom();
      cycle(s, m, "R4");
    end
    repeat (3) cycle('0, '0, "R4");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule